// File: doc/BRIEF.md
# Propagation Queue Sequencer

This block sequences Boolean constraint propagation for a single hardware SAT-solver instance. A decision literal enters through a valid/ready port and goes straight onto a broadcast bus that feeds a bank of processing elements. Each broadcast reaches those elements a fixed number of cycles later, and the block shows that moment on an arrival port. Implied literals come back from the reduction stage on two lanes. They are stored in a propagation FIFO, or they skip it, and the FIFO head is released onto the broadcast bus. Pops do not wait for earlier broadcasts to land, so several broadcasts can be in flight at the same time.

When the watch-list lookup reports a miss, the block starts the clause-fetch engine and keeps it running until memory reports completion. A conflict cancels everything in one cycle: the FIFO empties, in-flight broadcasts are dropped and the fetch engine stops. When no work remains, the block raises its idle status and accepts the next decision.

Literals are packed as `{index, value}`. The assigned value is the least significant bit.

Top module: `bcp_sequencer`

## Requirements
- R1: After reset, `idle` and `dec_ready` are 1, and `bc_valid`, `arr_valid`, `fetch_active` and `overflow` are 0.
- R2: A decision is taken only in a cycle where `dec_valid` and `dec_ready` are both 1. In that same cycle the decision literal appears on `bc_*`.
- R3: Every literal driven on `bc_*` appears on `arr_*` exactly `LAT` cycles later, with the same index and value.
- R4: When an implication arrives and the FIFO holds entries, the head is broadcast in that same cycle. The arriving literals are appended to the tail, lane 0 ahead of lane 1.
- R5: When an implication arrives and the FIFO is empty, the lane 0 literal (or the lane 1 literal if it arrives alone) is broadcast in that same cycle without being stored. A second literal in the same cycle is stored.
- R6: If no implication arrives, a stored literal is released only when no broadcast is in flight. While any broadcast is in flight, the FIFO holds.
- R7: The FIFO holds at most `DEPTH` literals. A pop in the same cycle frees one slot. Any literal that does not fit is dropped and sets `overflow`, which stays at 1 until reset. The order of the kept literals is unchanged.
- R8: A `wl_miss` sets `fetch_active` on the next cycle. `fetch_active` stays at 1 until `fetch_done` or a conflict. If `wl_miss` and `fetch_done` are both 1 in the same cycle, the miss wins.
- R9: In a cycle where `conflict` is 1, nothing is broadcast, no decision is taken and arriving implications are dropped. On the next cycle the FIFO is empty, `fetch_active` is 0 and no arrival appears for earlier broadcasts.
- R10: `idle` is 1 exactly when the FIFO is empty, no broadcast is in flight and no fetch is active. `dec_ready` is `idle` with `conflict` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decision offered |
| dec_ready | output | 1 | Decision accepted in this cycle if offered |
| dec_var | input | VAR_W | Decision variable index |
| dec_val | input | 1 | Decision value |
| imp0_valid | input | 1 | Lane 0 implication arrives (never back-pressured) |
| imp0_var | input | VAR_W | Lane 0 variable index |
| imp0_val | input | 1 | Lane 0 value |
| imp1_valid | input | 1 | Lane 1 implication arrives (never back-pressured) |
| imp1_var | input | VAR_W | Lane 1 variable index |
| imp1_val | input | 1 | Lane 1 value |
| wl_miss | input | 1 | Watch-list miss for an arriving literal |
| fetch_done | input | 1 | Clause fetch completed |
| conflict | input | 1 | Conflict reported, flush all work |
| bc_valid | output | 1 | Broadcast issued this cycle |
| bc_var | output | VAR_W | Broadcast variable index |
| bc_val | output | 1 | Broadcast value |
| arr_valid | output | 1 | A broadcast reaches the processing elements |
| arr_var | output | VAR_W | Arriving variable index |
| arr_val | output | 1 | Arriving value |
| fetch_active | output | 1 | Clause-fetch engine running |
| overflow | output | 1 | Sticky: a literal was dropped because the FIFO was full |
| idle | output | 1 | No pending, in-flight or fetch work |

## Verification
The bound checker checks these rules on every cycle:
- a conflict blocks the broadcast bus and clears fetch and arrivals on the next cycle;
- the fetch flag starts on a miss and then holds;
- `overflow` stays set;
- an accepted decision drives the bus;
- an implication that arrives while the block is idle goes straight to broadcast;
- the block is never ready while an arrival is showing.

The exact ordering of the FIFO, the `LAT`-cycle arrival timing, pacing while broadcasts are in flight, and dropping at capacity all depend on stored history. These only show up through the bench's cycle-by-cycle comparison with its own model of the queue and the broadcast path, under directed and random traffic.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  // Source feeding the broadcast bus in a given cycle.
  typedef enum logic [1:0] {
    BSRC_NONE   = 2'd0,
    BSRC_DEC    = 2'd1,
    BSRC_HEAD   = 2'd2,
    BSRC_BYPASS = 2'd3
  } bsrc_e;
endpackage

// File: rtl/bcp_lit_fifo.sv
module bcp_lit_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          p0_v,
  input  logic [W-1:0]  p0,
  input  logic          p1_v,
  input  logic [W-1:0]  p1,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   space;
  logic          acc0, acc1;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // A pop in the same cycle frees one slot for the pushes.
  assign space = (CW+1)'(DEPTH) - {1'b0, cnt_q} + {{CW{1'b0}}, pop};
  assign acc0  = p0_v && !flush && (space >= 1);
  assign acc1  = p1_v && !flush && (space >= 2);
  assign drop  = !flush && ((p0_v && !acc0) || (p1_v && !acc1));
  assign head  = mem[rp_q];
  assign cnt   = cnt_q;

  always_ff @(posedge clk) begin
    if (acc0) mem[wp_q] <= p0;
    if (acc1) mem[adv(wp_q)] <= p1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (acc1)      wp_q <= adv(adv(wp_q));
      else if (acc0) wp_q <= adv(wp_q);
      if (pop)       rp_q <= adv(rp_q);
      cnt_q <= cnt_q + CW'(acc0) + CW'(acc1) - CW'(pop);
    end
  end
endmodule

// File: rtl/bcp_bcast_pipe.sv
module bcp_bcast_pipe #(
  parameter int unsigned W   = 9,
  parameter int unsigned LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         in_v,
  input  logic [W-1:0] in_lit,
  output logic         out_v,
  output logic [W-1:0] out_lit,
  output logic         busy
);
  logic [LAT-1:0] v_q;
  logic [W-1:0]   l_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (clear) begin
      v_q <= '0;
    end else begin
      v_q[0] <= in_v;
      for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    l_q[0] <= in_lit;
    for (int i = 1; i < LAT; i++) l_q[i] <= l_q[i-1];
  end

  assign out_v   = v_q[LAT-1];
  assign out_lit = l_q[LAT-1];
  assign busy    = |v_q;
endmodule

// File: rtl/bcp_fetch_ctl.sv
module bcp_fetch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic miss,
  input  logic done,
  input  logic stop,
  output logic active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active <= 1'b0;
    else if (stop) active <= 1'b0;
    else if (miss) active <= 1'b1;
    else if (done) active <= 1'b0;
  end
endmodule

// File: rtl/bcp_sequencer.sv
module bcp_sequencer #(
  parameter int unsigned VAR_W = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LAT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  output logic             dec_ready,
  input  logic [VAR_W-1:0] dec_var,
  input  logic             dec_val,
  input  logic             imp0_valid,
  input  logic [VAR_W-1:0] imp0_var,
  input  logic             imp0_val,
  input  logic             imp1_valid,
  input  logic [VAR_W-1:0] imp1_var,
  input  logic             imp1_val,
  input  logic             wl_miss,
  input  logic             fetch_done,
  input  logic             conflict,
  output logic             bc_valid,
  output logic [VAR_W-1:0] bc_var,
  output logic             bc_val,
  output logic             arr_valid,
  output logic [VAR_W-1:0] arr_var,
  output logic             arr_val,
  output logic             fetch_active,
  output logic             overflow
  ,output logic            idle
);
  import bcp_pkg::*;

  localparam int unsigned LW = VAR_W + 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [LW-1:0] lit0, lit1, first, head, bc_lit, arr_lit, f_p0;
  logic [CW-1:0] cnt;
  logic          any_imp, both_imp, fifo_empty, busy, dec_fire;
  logic          f_p0_v, f_p1_v, f_drop, ovf_q;
  bsrc_e         src;

  assign lit0     = {imp0_var, imp0_val};
  assign lit1     = {imp1_var, imp1_val};
  assign any_imp  = imp0_valid | imp1_valid;
  assign both_imp = imp0_valid & imp1_valid;
  assign first    = imp0_valid ? lit0 : lit1;

  assign fifo_empty = (cnt == '0);
  assign idle       = fifo_empty & ~busy & ~fetch_active;
  assign dec_ready  = idle & ~conflict;
  assign dec_fire   = dec_valid & dec_ready;

  // Broadcast slot arbitration: conflict, decision, FIFO head, bypass.
  always_comb begin
    src = BSRC_NONE;
    if (conflict)                               src = BSRC_NONE;
    else if (dec_fire)                          src = BSRC_DEC;
    else if ((any_imp | ~busy) && !fifo_empty)  src = BSRC_HEAD;
    else if (any_imp)                           src = BSRC_BYPASS;
  end

  always_comb begin
    unique case (src)
      BSRC_DEC:    bc_lit = {dec_var, dec_val};
      BSRC_HEAD:   bc_lit = head;
      BSRC_BYPASS: bc_lit = first;
      default:     bc_lit = '0;
    endcase
  end

  assign bc_valid = (src != BSRC_NONE);
  assign bc_var   = bc_lit[LW-1:1];
  assign bc_val   = bc_lit[0];

  // In bypass, the first literal goes to the bus and only a second one is stored.
  always_comb begin
    if (src == BSRC_BYPASS) begin
      f_p0_v = both_imp;
      f_p0   = lit1;
      f_p1_v = 1'b0;
    end else begin
      f_p0_v = any_imp;
      f_p0   = first;
      f_p1_v = both_imp;
    end
  end

  bcp_lit_fifo #(.W(LW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (conflict),
    .p0_v  (f_p0_v),
    .p0    (f_p0),
    .p1_v  (f_p1_v),
    .p1    (lit1),
    .pop   (src == BSRC_HEAD),
    .head  (head),
    .cnt   (cnt),
    .drop  (f_drop)
  );

  bcp_bcast_pipe #(.W(LW), .LAT(LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (conflict),
    .in_v    (bc_valid),
    .in_lit  (bc_lit),
    .out_v   (arr_valid),
    .out_lit (arr_lit),
    .busy    (busy)
  );

  assign arr_var = arr_lit[LW-1:1];
  assign arr_val = arr_lit[0];

  bcp_fetch_ctl u_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .miss   (wl_miss),
    .done   (fetch_done),
    .stop   (conflict),
    .active (fetch_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (f_drop) ovf_q <= 1'b1;
  end
  assign overflow = ovf_q;
endmodule

// File: rtl/bcp_sequencer_chk.sv
module bcp_sequencer_chk #(
  parameter int unsigned VAR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic [VAR_W-1:0] dec_var,
  input logic             dec_val,
  input logic             imp0_valid,
  input logic [VAR_W-1:0] imp0_var,
  input logic             imp0_val,
  input logic             wl_miss,
  input logic             fetch_done,
  input logic             conflict,
  input logic             bc_valid,
  input logic [VAR_W-1:0] bc_var,
  input logic             bc_val,
  input logic             arr_valid,
  input logic             fetch_active,
  input logic             overflow
);
  p_conflict_no_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !bc_valid);

  p_conflict_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> (!fetch_active && !arr_valid));

  p_miss_starts_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_miss && !conflict) |=> fetch_active);

  p_fetch_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_active && !fetch_done && !conflict) |=> fetch_active);

  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_decision_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready) |-> (bc_valid && bc_var == dec_var && bc_val == dec_val));

  p_idle_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && !dec_valid && imp0_valid) |-> (bc_valid && bc_var == imp0_var && bc_val == imp0_val));

  p_ready_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ready |-> !arr_valid);
endmodule

bind bcp_sequencer bcp_sequencer_chk #(.VAR_W(VAR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid    (dec_valid),
  .dec_ready    (dec_ready),
  .dec_var      (dec_var),
  .dec_val      (dec_val),
  .imp0_valid   (imp0_valid),
  .imp0_var     (imp0_var),
  .imp0_val     (imp0_val),
  .wl_miss      (wl_miss),
  .fetch_done   (fetch_done),
  .conflict     (conflict),
  .bc_valid     (bc_valid),
  .bc_var       (bc_var),
  .bc_val       (bc_val),
  .arr_valid    (arr_valid),
  .fetch_active (fetch_active),
  .overflow     (overflow)
);

// File: tb/bcp_sequencer_test.sv
module bcp_sequencer_test;
  localparam int unsigned VAR_W = 8;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned LAT   = 4;
  localparam int unsigned LW    = VAR_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_val = 0, imp0_valid = 0, imp0_val = 0, imp1_valid = 0, imp1_val = 0;
  logic [VAR_W-1:0] dec_var = '0, imp0_var = '0, imp1_var = '0;
  logic wl_miss = 0, fetch_done = 0, conflict = 0;
  logic dec_ready, bc_valid, bc_val, arr_valid, arr_val, fetch_active, overflow, idle;
  logic [VAR_W-1:0] bc_var, arr_var;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  bcp_sequencer #(.VAR_W(VAR_W), .DEPTH(DEPTH), .LAT(LAT)) uut (.*);

  // Reference model state
  logic [LW-1:0] mq[$];
  logic          mi_v [LAT];
  logic [LW-1:0] mi_l [LAT];
  logic          m_fetch = 0, m_ovf = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic bit m_busy();
    for (int i = 0; i < LAT; i++) if (mi_v[i]) return 1;
    return 0;
  endfunction

  task automatic step(input string tag,
                      input logic dv, input logic [VAR_W-1:0] dvar, input logic dval,
                      input logic a_v, input logic [VAR_W-1:0] a_var, input logic a_val,
                      input logic b_v, input logic [VAR_W-1:0] b_var, input logic b_val,
                      input logic miss, input logic fdone, input logic conf);
    logic [LW-1:0] inc[$];
    logic e_idle, e_rdy, e_bv, e_fire, trig;
    logic [LW-1:0] e_bl;
    @(negedge clk);
    dec_valid = dv; dec_var = dvar; dec_val = dval;
    imp0_valid = a_v; imp0_var = a_var; imp0_val = a_val;
    imp1_valid = b_v; imp1_var = b_var; imp1_val = b_val;
    wl_miss = miss; fetch_done = fdone; conflict = conf;
    #1;
    e_idle = (mq.size() == 0) && !m_busy() && !m_fetch;
    e_rdy  = e_idle && !conf;
    e_fire = dv && e_rdy;
    e_bv = 0; e_bl = '0;
    if (a_v) inc.push_back({a_var, a_val});
    if (b_v) inc.push_back({b_var, b_val});
    if (!conf) begin
      trig = (a_v || b_v) || !m_busy();
      if (e_fire) begin
        e_bv = 1; e_bl = {dvar, dval};
      end else if (trig && (mq.size() > 0 || inc.size() > 0)) begin
        e_bv = 1;
        e_bl = (mq.size() > 0) ? mq.pop_front() : inc.pop_front();
      end
    end
    n_tests++;
    if (dec_ready !== e_rdy || idle !== e_idle || bc_valid !== e_bv ||
        (e_bv && {bc_var, bc_val} !== e_bl) || arr_valid !== mi_v[LAT-1] ||
        (mi_v[LAT-1] && {arr_var, arr_val} !== mi_l[LAT-1]) ||
        fetch_active !== m_fetch || overflow !== m_ovf) begin
      n_fail++;
      $display("FAIL %s cyc %0d: actual rdy=%b idle=%b bc=%b/%h arr=%b/%h fetch=%b ovf=%b expected rdy=%b idle=%b bc=%b/%h arr=%b/%h fetch=%b ovf=%b",
               tag, cyc, dec_ready, idle, bc_valid, {bc_var, bc_val}, arr_valid, {arr_var, arr_val},
               fetch_active, overflow, e_rdy, e_idle, e_bv, e_bl, mi_v[LAT-1], mi_l[LAT-1], m_fetch, m_ovf);
    end
    // Advance the model to the next cycle.
    if (conf) begin
      mq.delete();
      for (int i = 0; i < LAT; i++) mi_v[i] = 0;
      m_fetch = 0;
    end else begin
      while (inc.size() > 0) begin
        if (mq.size() < DEPTH) mq.push_back(inc.pop_front());
        else begin void'(inc.pop_front()); m_ovf = 1; end
      end
      if (miss) m_fetch = 1; else if (fdone) m_fetch = 0;
      for (int i = LAT - 1; i > 0; i--) begin mi_v[i] = mi_v[i-1]; mi_l[i] = mi_l[i-1]; end
      mi_v[0] = e_bv; mi_l[0] = e_bl;
    end
  endtask

  task automatic idle_cyc(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) begin mi_v[i] = 0; mi_l[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    idle_cyc("R1");
    // R2 and R3: decision broadcast, arrival LAT cycles later
    step("R2", 1, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (LAT + 1) idle_cyc("R3");
    // R5: bypass from empty FIFO, both lanes; R6: paced drain
    step("R5", 0, 0, 0, 1, 8'h02, 1, 1, 8'h03, 0, 0, 0, 0);
    repeat (LAT + 2) idle_cyc("R6");
    // R4: head broadcast with pushes, lane order
    step("R4", 0, 0, 0, 1, 8'h0C, 0, 1, 8'h63, 1, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 8'h10, 1, 1, 8'h11, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 8'h12, 0, 0, 0, 0);
    repeat (3 * (LAT + 1)) idle_cyc("R6");
    // R8: miss and done arbitration
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    idle_cyc("R8");
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle_cyc("R10");
    // R7: fill past capacity
    for (int k = 0; k < 22; k++)
      step("R7", 0, 0, 0, 1, VAR_W'(2 * k), 1, 1, VAR_W'(2 * k + 1), 0, 0, 0, 0);
    // R9: conflict with pushes in the same cycle, plus fetch running
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R9", 1, 8'h55, 1, 1, 8'hAA, 0, 1, 8'hBB, 1, 0, 0, 1);
    repeat (LAT + 1) idle_cyc("R9");
    // Random traffic
    for (int k = 0; k < 3000; k++)
      step("R4", ($urandom % 2) == 0, VAR_W'($urandom), 1'($urandom),
           ($urandom % 10) < 3, VAR_W'($urandom), 1'($urandom),
           ($urandom % 10) < 3, VAR_W'($urandom), 1'($urandom),
           ($urandom % 20) == 0, ($urandom % 10) == 0, ($urandom % 40) == 0);
    repeat (40) idle_cyc("R10");
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule